// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a word-organized on-chip scratchpad split into many independent single-ported banks. It accepts one access on behalf of a whole group of lanes, which is 32 by default. Each lane carries a word address, an active flag and, for stores, a data word. The block finds the bank that each active lane's address falls in. In every service cycle each bank serves exactly one distinct word address.

Lanes that want the same word in the same bank are served together. On a load they all receive the same word in that cycle. Lanes that land in one bank at different words wait for later cycles. Within a bank, the lowest-numbered pending lane picks the word that is served next.

When every lane has been served, the block raises a one-cycle completion pulse. Along with it the block presents the read data for all lanes and the number of service cycles the access took. That number equals the worst per-bank count of distinct words. The usual use is to hold a tile of operands that many lanes read and write in parallel. Padding a row stride so that column walks spread over the banks removes the serialization.

Top module: `banked_scratchpad`

## Requirements
- R1: The bank of a lane is the low log2(BANKS) bits of its word address, and the row inside the bank is the remaining upper bits. A word stored at any address reads back unchanged from that same address, and words at different addresses in one bank stay separate.
- R2: An access whose active lanes all fall in different banks completes in one service cycle (`cycles_used` = 1).
- R3: `cycles_used` equals the largest number of distinct word addresses among the active lanes that map to any one bank. For example, 32 lanes on word addresses 0, 32, 64, … take 32 cycles, and three distinct words in one bank plus one shared word elsewhere take 3 cycles.
- R4: Active lanes that load the same word are served together. They all receive that word and add no service cycle.
- R5: A column walk with a padded row stride of 33 words (lane l at word 33·l) spreads over all banks and completes in one service cycle.
- R6: When several active lanes store to the same word, the word keeps the data of the highest-numbered of those lanes.
- R7: Inactive lanes do not write the scratchpad, and their `rd_data` slot reads as zero after a load.
- R8: `done` is high for exactly one cycle after the last service cycle, and `busy` stays high from acceptance through that cycle. An access with no active lane takes one service cycle.
- R9: A request presented while `busy` is high is ignored, so it changes no stored word.
- R10: After reset, `busy` and `done` are low and `cycles_used` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an access; taken only while `busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_active | input | LANES | Per-lane active flag |
| req_addr | input | LANES*AW | Per-lane word address, lane l at bits [l*AW +: AW] |
| req_wdata | input | LANES*DW | Per-lane store data, lane l at bits [l*DW +: DW] |
| busy | output | 1 | Access in progress; new requests are refused |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | LANES*DW | Per-lane load result, valid from `done` until the next access |
| cycles_used | output | $clog2(LANES+1) | Service cycles taken by the last access |

## Verification
The bench drives the stride-32 column walk that piles all lanes into one bank. A design that forgot to serialize would report one cycle and lose all but one stored word. It also drives the stride-33 walk, where a design with the wrong bank mapping would stall. Full broadcasts and a mix of one conflicting bank with a broadcast elsewhere catch a design that counts lanes instead of distinct words. Stores by many lanes to one word show whether the winning lane is chosen by number or by arbitrary order. Partial and empty masks, together with a request injected mid-access, expose designs that write on behalf of inactive lanes, hang with no work, or accept a second request while busy.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
   typedef enum logic [1:0] {
      SP_IDLE = 2'd0,
      SP_RUN  = 2'd1,
      SP_DONE = 2'd2
   } sp_state_e;
endpackage

// File: rtl/sp_bank_arb.sv
// Per-bank selector: lowest pending lane picks the word; every pending lane
// on that same word rides along. Also reports the highest rider for stores.
module sp_bank_arb #(
   parameter int LANES = 32,
   parameter int AW    = 10,
   localparam int LIW  = $clog2(LANES)
) (
   input  logic [LANES-1:0]    hit,
   input  logic [LANES*AW-1:0] addr,
   output logic [LANES-1:0]    grant,
   output logic [AW-1:0]       lead_addr,
   output logic [LIW-1:0]      last_idx,
   output logic                any
);
   always_comb begin
      any       = 1'b0;
      lead_addr = '0;
      for (int l = 0; l < LANES; l++) begin
         if (hit[l] && !any) begin
            any       = 1'b1;
            lead_addr = addr[l*AW +: AW];
         end
      end
      last_idx = '0;
      for (int l = 0; l < LANES; l++) begin
         grant[l] = hit[l] && (addr[l*AW +: AW] == lead_addr);
         if (grant[l]) last_idx = LIW'(l);
      end
   end
endmodule

// File: rtl/sp_bank.sv
// One single-ported word bank: combinational read, clocked write.
module sp_bank #(
   parameter int DW   = 32,
   parameter int ROWS = 32,
   localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) mem[row] <= wdata;
   end

   assign rdata = mem[row];
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
   import scratch_pkg::*;
#(
   parameter int LANES = 32,
   parameter int BANKS = 32,
   parameter int AW    = 10,
   parameter int DW    = 32,
   localparam int BW   = $clog2(BANKS),
   localparam int RW   = AW - BW,
   localparam int ROWS = 1 << RW,
   localparam int LIW  = $clog2(LANES),
   localparam int CW   = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [LANES-1:0]    req_active,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES*DW-1:0] req_wdata,
   output logic                busy,
   output logic                done,
   output logic [LANES*DW-1:0] rd_data,
   output logic [CW-1:0]       cycles_used
);
   if ((BANKS & (BANKS - 1)) != 0 || BANKS < 2)
      $error("BANKS must be a power of two, at least 2");
   if (AW <= BW)
      $error("AW must leave at least one row bit above the bank bits");
   if (LANES < 2)
      $error("LANES must be at least 2");

   sp_state_e             state_q;
   logic [LANES*AW-1:0]   addr_q;
   logic [LANES*DW-1:0]   wdata_q;
   logic                  wr_q;
   logic [LANES-1:0]      pend_q;
   logic [LANES*DW-1:0]   rd_q;
   logic [CW-1:0]         cnt_q;

   logic [BANKS-1:0][LANES-1:0] hit;
   logic [BANKS-1:0][LANES-1:0] grant;
   logic [LANES-1:0]            served;
   logic [DW-1:0]               brd [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [AW-1:0]  lead_addr;
      logic [LIW-1:0] last_idx;
      logic           any;

      for (genvar l = 0; l < LANES; l++) begin : g_hit
         assign hit[b][l] = (state_q == SP_RUN) && pend_q[l] &&
                            (addr_q[l*AW +: BW] == BW'(b));
      end

      sp_bank_arb #(.LANES(LANES), .AW(AW)) u_arb (
         .hit       (hit[b]),
         .addr      (addr_q),
         .grant     (grant[b]),
         .lead_addr (lead_addr),
         .last_idx  (last_idx),
         .any       (any)
      );

      sp_bank #(.DW(DW), .ROWS(ROWS)) u_mem (
         .clk   (clk),
         .we    (wr_q && any),
         .row   (lead_addr[AW-1:BW]),
         .wdata (wdata_q[int'(last_idx)*DW +: DW]),
         .rdata (brd[b])
      );
   end

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) served = served | grant[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SP_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         pend_q  <= '0;
         rd_q    <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SP_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  wr_q    <= req_write;
                  pend_q  <= req_active;
                  rd_q    <= '0;
                  cnt_q   <= '0;
                  state_q <= SP_RUN;
               end
            end
            SP_RUN: begin
               pend_q <= pend_q & ~served;
               cnt_q  <= cnt_q + 1'b1;
               for (int l = 0; l < LANES; l++) begin
                  if (served[l] && !wr_q)
                     rd_q[l*DW +: DW] <= brd[addr_q[l*AW +: BW]];
               end
               if ((pend_q & ~served) == '0) state_q <= SP_DONE;
            end
            default: state_q <= SP_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != SP_IDLE);
   assign done        = (state_q == SP_DONE);
   assign rd_data     = rd_q;
   assign cycles_used = cnt_q;

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_serve_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SP_RUN) |-> ((served & ~pend_q) == '0));

   assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SP_RUN && pend_q != '0) |-> (served != '0));

   assert_cycle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycles_used >= CW'(1) && cycles_used <= CW'(LANES)));

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SP_RUN) |=> ($stable(wr_q) && $stable(addr_q)));
endmodule

// File: tb/tb_banked_scratchpad.sv
`timescale 1ns/1ps
module tb_banked_scratchpad;
   localparam int LANES = 32;
   localparam int AW    = 10;
   localparam int DW    = 32;
   localparam int CW    = $clog2(LANES + 1);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_write = 1'b0;
   logic [LANES-1:0]    req_active = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic [LANES*DW-1:0] req_wdata = '0;
   logic                busy, done;
   logic [LANES*DW-1:0] rd_data;
   logic [CW-1:0]       cycles_used;

   int n_tests = 0;
   int n_fail  = 0;

   int          a_addr [LANES];
   logic [31:0] a_wd   [LANES];
   logic [31:0] rd     [LANES];
   int          cyc;

   always #2.5 clk = ~clk;

   banked_scratchpad dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_active(req_active), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .cycles_used(cycles_used)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input bit wr, input logic [LANES-1:0] act);
      int guard = 0;
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_active = act;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*AW +: AW]  = AW'(a_addr[l]);
         req_wdata[l*DW +: DW] = a_wd[l];
      end
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      if (!done) chk(1'b0, "watchdog access hung", 0, 1);
      cyc = int'(cycles_used);
      for (int l = 0; l < LANES; l++) rd[l] = rd_data[l*DW +: DW];
      @(negedge clk);
      chk(!done, "R8 done lasts one cycle", done, 0);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R10 busy after reset", busy, 0);
      chk(done == 1'b0, "R10 done after reset", done, 0);
      chk(cycles_used == '0, "R10 cycles after reset", cycles_used, 0);
   endtask

   task automatic t_linear();
      int bad = 0;
      for (int l = 0; l < LANES; l++) begin a_addr[l] = l; a_wd[l] = 32'h1000 + l; end
      run(1'b1, '1);
      chk(cyc == 1, "R2 linear store cycles", cyc, 1);
      for (int l = 0; l < LANES; l++) a_wd[l] = 0;
      run(1'b0, '1);
      chk(cyc == 1, "R2 linear load cycles", cyc, 1);
      for (int l = 0; l < LANES; l++) if (rd[l] != 32'h1000 + l) bad++;
      chk(bad == 0, "R1 linear readback mismatches", bad, 0);
   endtask

   task automatic t_stride32();
      int bad = 0;
      for (int l = 0; l < LANES; l++) begin a_addr[l] = l * 32; a_wd[l] = 32'h2000 + l; end
      run(1'b1, '1);
      chk(cyc == 32, "R3 stride32 store cycles", cyc, 32);
      run(1'b0, '1);
      chk(cyc == 32, "R3 stride32 load cycles", cyc, 32);
      for (int l = 0; l < LANES; l++) if (rd[l] != 32'h2000 + l) bad++;
      chk(bad == 0, "R1 same-bank rows kept apart", bad, 0);
   endtask

   task automatic t_stride33();
      int bad = 0;
      for (int l = 0; l < LANES; l++) begin a_addr[l] = l * 33; a_wd[l] = 32'h3000 + l; end
      run(1'b1, '1);
      chk(cyc == 1, "R5 stride33 store cycles", cyc, 1);
      run(1'b0, '1);
      chk(cyc == 1, "R5 stride33 load cycles", cyc, 1);
      for (int l = 0; l < LANES; l++) if (rd[l] != 32'h3000 + l) bad++;
      chk(bad == 0, "R5 stride33 readback", bad, 0);
   endtask

   task automatic t_broadcast();
      int bad = 0;
      for (int l = 0; l < LANES; l++) a_addr[l] = 5;
      run(1'b0, '1);
      chk(cyc == 1, "R4 broadcast cycles", cyc, 1);
      for (int l = 0; l < LANES; l++) if (rd[l] != 32'h1005) bad++;
      chk(bad == 0, "R4 broadcast data", bad, 0);
      a_addr[0] = 0; a_addr[1] = 32; a_addr[2] = 64;
      for (int l = 3; l < LANES; l++) a_addr[l] = 7;
      run(1'b0, '1);
      chk(cyc == 3, "R3 mixed conflict plus broadcast cycles", cyc, 3);
      chk(rd[2] == 32'h2002, "R3 mixed lane2 data", rd[2], 32'h2002);
      chk(rd[20] == 32'h1007, "R4 mixed broadcast data", rd[20], 32'h1007);
   endtask

   task automatic t_dup_write();
      for (int l = 0; l < LANES; l++) begin a_addr[l] = 100; a_wd[l] = 32'h4000 + l; end
      run(1'b1, '1);
      chk(cyc == 1, "R6 duplicate store cycles", cyc, 1);
      run(1'b0, 32'h1);
      chk(rd[0] == 32'h401F, "R6 highest lane wins", rd[0], 32'h401F);
      run(1'b1, 32'h0000_FFFF);
      run(1'b0, 32'h1);
      chk(rd[0] == 32'h400F, "R6 highest active lane wins", rd[0], 32'h400F);
   endtask

   task automatic t_inactive();
      int bad = 0;
      for (int l = 0; l < LANES; l++) begin a_addr[l] = 200 + l; a_wd[l] = 32'h5000 + l; end
      run(1'b1, '1);
      for (int l = 0; l < LANES; l++) a_wd[l] = 32'h6000 + l;
      run(1'b1, 32'h5555_5555);
      run(1'b0, '1);
      for (int l = 0; l < LANES; l++)
         if (rd[l] != ((l % 2 == 0) ? 32'h6000 + l : 32'h5000 + l)) bad++;
      chk(bad == 0, "R7 inactive lanes did not store", bad, 0);
      run(1'b0, 32'h0000_000F);
      chk(rd[4] == 0 && rd[31] == 0, "R7 inactive lane read is zero", rd[4], 0);
      chk(rd[3] == 32'h5003, "R7 active lane read", rd[3], 32'h5003);
      run(1'b0, '0);
      chk(cyc == 1, "R8 empty mask takes one cycle", cyc, 1);
   endtask

   task automatic t_busy_ignore();
      for (int l = 0; l < LANES; l++) begin a_addr[l] = 900; a_wd[l] = 32'h7777; end
      run(1'b1, 32'h1);
      for (int l = 0; l < LANES; l++) begin a_addr[l] = l * 32 + 1; a_wd[l] = 32'h8000 + l; end
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_active = '1;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*AW +: AW]  = AW'(a_addr[l]);
         req_wdata[l*DW +: DW] = a_wd[l];
      end
      @(negedge clk);
      chk(busy == 1'b1, "R8 busy after accept", busy, 1);
      for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = AW'(900);
      for (int l = 0; l < LANES; l++) req_wdata[l*DW +: DW] = 32'hDEAD;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(cycles_used == 32, "R3 stride32 offset cycles", cycles_used, 32);
      @(negedge clk);
      for (int l = 0; l < LANES; l++) a_addr[l] = 900;
      run(1'b0, 32'h1);
      chk(rd[0] == 32'h7777, "R9 request while busy ignored", rd[0], 32'h7777);
   endtask

   initial begin
      #(5.0 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int l = 0; l < LANES; l++) begin a_addr[l] = 0; a_wd[l] = 0; end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_linear();
      t_stride32();
      t_stride33();
      t_broadcast();
      t_dup_write();
      t_inactive();
      t_busy_ignore();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule